// File: doc/BRIEF.md
# Vertical Sync Period and Phase Meter

This block sits beside a frame-buffered video scaler and measures two vertical sync lines with one free-running cycle counter. One line is the source field sync. The other is the scaler's output frame sync. A single start strobe runs one measurement round. The round reports the source field period, the output frame period, and the delay from a source sync edge to the next output sync edge. The delay is also given as a binary fraction of the source period. A rate controller can use these results to steer the output clock so that the buffer tear point stays outside the visible picture.

A round steps through four rising edges in a fixed order: two on the source line, then two on the output line. The delay is taken from the second source edge to the first output edge that follows it. All four stamps come from the same counter, so the three results can be compared directly. A delay of one source period or more is folded down by that period. A missed output edge therefore still yields the correct phase.

A round fails and reports zeros in two cases. The first is when an edge does not arrive within the programmed number of cycles. The second is when two stamps are zero or out of order, which happens when the counter wraps between them. Results stay registered until the next start.

Top module: `vsm_vsync_meter`

## Requirements
- R1: While reset is asserted and after it is released, all result outputs read zero and valid and both error flags are low until a round ends. The stamp counter starts from zero at reset release and adds one on every clock.
- R2: The source period equals the number of clock cycles between the first two rising edges of the source sync line seen after start.
- R3: The output period equals the number of clock cycles between the first two rising edges of the output sync line that follow the second source edge.
- R4: The latency equals the number of cycles from the second source edge to the first following output edge, reduced modulo the source period. It is always less than the source period, so a delay of exactly one period reads zero.
- R5: The latency fraction equals floor(latency * 2^FRAC_W / source period), where FRAC_W is the fraction width (8 in the bench).
- R6: A successful round raises valid for exactly one cycle. All results appear on that same cycle and then hold unchanged, whatever the sync lines do, until the next start.
- R7: If any awaited edge fails to arrive within the timeout (in clock cycles), the round ends with the no-pulse flag high, valid never high, and all results zero.
- R8: If a stamp pair has a zero stamp, or its later stamp is not greater than its earlier stamp (for example because the counter wrapped), the round ends with the bad-result flag high, valid never high, and all results zero.
- R9: A start strobe at any time, including during a round, clears the results and both flags and begins a new round from the first source edge.
- R10: The sync lines are only sampled on rising edges after a synchronizer. A line that stays high counts once, and edges seen while no round is running have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle strobe that begins a round |
| timeout_i | input | TO_W | Maximum cycles to wait for each edge |
| vs_in_i | input | 1 | Source vertical sync, asynchronous |
| vs_out_i | input | 1 | Output vertical sync, asynchronous |
| in_period_o | output | CNT_W | Source field period in cycles |
| out_period_o | output | CNT_W | Output frame period in cycles |
| latency_o | output | CNT_W | Source-to-output delay, folded, in cycles |
| lat_frac_o | output | FRAC_W | Delay as a fraction of the source period |
| valid_o | output | 1 | One-cycle pulse on successful completion |
| err_nopulse_o | output | 1 | Round ended because an edge timed out |
| err_bad_o | output | 1 | Round ended on a zero or reversed stamp |

## Verification
The bench targets a delay of exactly one source period and a delay longer than two periods. Both must fold to the right residue. A design that skipped folding, or folded only once, would report a value at or above the period along with a wrong fraction. It also places the two source edges on either side of a counter wrap. A design without the ordering check would then report a huge bogus period instead of the bad-result flag. Timeouts are tested both before the first edge and between edges, a restart is issued in mid-round, and the sync lines are toggled after completion. A design that dropped the hold, timed out in the wrong place or kept stale state would show changed or non-zero results.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_IN_A,
      ST_IN_B,
      ST_OUT_C,
      ST_OUT_D,
      ST_FOLD,
      ST_DIV
   } vsm_state_e;
endpackage

// File: rtl/vsm_sync_edge.sv
module vsm_sync_edge #(
   parameter int STAGES   = 2,
   parameter bit POL_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic edge_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("vsm_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         last <= 1'b0;
      end else begin
         sh   <= {sh[STAGES-2:0], d_i};
         last <= sh[STAGES-1];
      end
   end

   generate
      if (POL_RISE) begin : g_rise
         assign edge_o = sh[STAGES-1] & ~last;
      end else begin : g_fall
         assign edge_o = ~sh[STAGES-1] & last;
      end
   endgenerate
endmodule

// File: rtl/vsm_frac_div.sv
module vsm_frac_div #(
   parameter int NUM_W  = 32,
   parameter int FRAC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [NUM_W-1:0]  num_i,
   input  logic [NUM_W-1:0]  den_i,
   output logic              done_o,
   output logic [FRAC_W-1:0] quo_o
);
   localparam int CW = $clog2(FRAC_W + 1);

   generate
      if (FRAC_W < 2) begin : g_bad_frac
         $error("vsm_frac_div: FRAC_W must be at least 2");
      end
   endgenerate

   logic [NUM_W-1:0] rem;
   logic [CW-1:0]    left;
   logic             run;
   logic [NUM_W:0]   dbl;
   logic [NUM_W:0]   den_x;
   logic             take;

   assign dbl   = {rem, 1'b0};
   assign den_x = {1'b0, den_i};
   assign take  = (dbl >= den_x);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem    <= '0;
         left   <= '0;
         run    <= 1'b0;
         done_o <= 1'b0;
         quo_o  <= '0;
      end else begin
         done_o <= 1'b0;
         if (go_i && !run) begin
            rem   <= num_i;
            quo_o <= '0;
            left  <= CW'(FRAC_W);
            run   <= 1'b1;
         end else if (run) begin
            if (take) begin
               rem <= NUM_W'(dbl - den_x);
            end else begin
               rem <= dbl[NUM_W-1:0];
            end
            quo_o <= {quo_o[FRAC_W-2:0], take};
            left  <= left - 1'b1;
            if (left == CW'(1)) begin
               run    <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/vsm_vsync_meter.sv
module vsm_vsync_meter
   import vsm_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int TO_W        = 24,
   parameter int FRAC_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [TO_W-1:0]   timeout_i,
   input  logic              vs_in_i,
   input  logic              vs_out_i,
   output logic [CNT_W-1:0]  in_period_o,
   output logic [CNT_W-1:0]  out_period_o,
   output logic [CNT_W-1:0]  latency_o,
   output logic [FRAC_W-1:0] lat_frac_o,
   output logic              valid_o,
   output logic              err_nopulse_o,
   output logic              err_bad_o
);
   generate
      if (CNT_W < 4) begin : g_bad_cnt
         $error("vsm_vsync_meter: CNT_W must be at least 4");
      end
      if (TO_W < 1) begin : g_bad_to
         $error("vsm_vsync_meter: TO_W must be at least 1");
      end
   endgenerate

   vsm_state_e        st;
   logic [CNT_W-1:0]  tick;
   logic [CNT_W-1:0]  stamp_ref;
   logic [CNT_W-1:0]  per_in;
   logic [CNT_W-1:0]  per_out;
   logic [CNT_W-1:0]  lat;
   logic [TO_W-1:0]   wait_cnt;
   logic              rise_in;
   logic              rise_out;
   logic              waiting;
   logic              want_in;
   logic              hit;
   logic              expired;
   logic              stamp_bad;
   logic              div_go;
   logic              div_done;
   logic [FRAC_W-1:0] div_q;

   vsm_sync_edge #(.STAGES(SYNC_STAGES), .POL_RISE(1'b1)) u_sync_in (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (vs_in_i),
      .edge_o(rise_in)
   );

   vsm_sync_edge #(.STAGES(SYNC_STAGES), .POL_RISE(1'b1)) u_sync_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (vs_out_i),
      .edge_o(rise_out)
   );

   vsm_frac_div #(.NUM_W(CNT_W), .FRAC_W(FRAC_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go_i  (div_go),
      .num_i (lat),
      .den_i (per_in),
      .done_o(div_done),
      .quo_o (div_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick <= '0;
      else        tick <= tick + 1'b1;
   end

   assign waiting   = (st == ST_IN_A) || (st == ST_IN_B) ||
                      (st == ST_OUT_C) || (st == ST_OUT_D);
   assign want_in   = (st == ST_IN_A) || (st == ST_IN_B);
   assign hit       = want_in ? rise_in : rise_out;
   assign expired   = waiting && !hit && (wait_cnt >= timeout_i);
   // a stamp pair is rejected when either end is zero or order is not strict
   assign stamp_bad = (tick == '0) || ((st != ST_IN_A) && (stamp_ref >= tick));
   assign div_go    = (st == ST_FOLD) && (lat < per_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= ST_IDLE;
         stamp_ref     <= '0;
         per_in        <= '0;
         per_out       <= '0;
         lat           <= '0;
         wait_cnt      <= '0;
         in_period_o   <= '0;
         out_period_o  <= '0;
         latency_o     <= '0;
         lat_frac_o    <= '0;
         valid_o       <= 1'b0;
         err_nopulse_o <= 1'b0;
         err_bad_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (start_i) begin
            st            <= ST_IN_A;
            wait_cnt      <= '0;
            in_period_o   <= '0;
            out_period_o  <= '0;
            latency_o     <= '0;
            lat_frac_o    <= '0;
            err_nopulse_o <= 1'b0;
            err_bad_o     <= 1'b0;
         end else if (waiting) begin
            if (hit) begin
               wait_cnt <= '0;
               if (stamp_bad) begin
                  err_bad_o <= 1'b1;
                  st        <= ST_IDLE;
               end else begin
                  stamp_ref <= tick;
                  unique case (st)
                     ST_IN_A:  st <= ST_IN_B;
                     ST_IN_B: begin
                        per_in <= tick - stamp_ref;
                        st     <= ST_OUT_C;
                     end
                     ST_OUT_C: begin
                        lat <= tick - stamp_ref;
                        st  <= ST_OUT_D;
                     end
                     default: begin
                        per_out <= tick - stamp_ref;
                        st      <= ST_FOLD;
                     end
                  endcase
               end
            end else if (expired) begin
               err_nopulse_o <= 1'b1;
               st            <= ST_IDLE;
            end else begin
               wait_cnt <= wait_cnt + 1'b1;
            end
         end else if (st == ST_FOLD) begin
            if (lat >= per_in) lat <= lat - per_in;
            else               st  <= ST_DIV;
         end else if (st == ST_DIV) begin
            if (div_done) begin
               in_period_o  <= per_in;
               out_period_o <= per_out;
               latency_o    <= lat;
               lat_frac_o   <= div_q;
               valid_o      <= 1'b1;
               st           <= ST_IDLE;
            end
         end
      end
   end
endmodule

// File: rtl/vsm_vsync_meter_chk.sv
module vsm_vsync_meter_chk #(
   parameter int CNT_W  = 32,
   parameter int FRAC_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [CNT_W-1:0]  in_period_o,
   input logic [CNT_W-1:0]  out_period_o,
   input logic [CNT_W-1:0]  latency_o,
   input logic [FRAC_W-1:0] lat_frac_o,
   input logic              valid_o,
   input logic              err_nopulse_o,
   input logic              err_bad_o
);
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R6

   AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start_i) && !valid_o) |-> ($stable(in_period_o) && $stable(latency_o)
                                         && $stable(out_period_o) && $stable(lat_frac_o))); // R6

   AST_LAT_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (latency_o < in_period_o)); // R4

   AST_PERIODS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (in_period_o != '0 && out_period_o != '0)); // R2

   AST_NOPULSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      err_nopulse_o |-> (!valid_o && in_period_o == '0 && latency_o == '0)); // R7

   AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      err_bad_o |-> (!valid_o && in_period_o == '0 && out_period_o == '0)); // R8

   AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_nopulse_o, err_bad_o})); // R7

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!err_nopulse_o && !err_bad_o && !valid_o)); // R9
endmodule

bind vsm_vsync_meter vsm_vsync_meter_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .in_period_o  (in_period_o),
   .out_period_o (out_period_o),
   .latency_o    (latency_o),
   .lat_frac_o   (lat_frac_o),
   .valid_o      (valid_o),
   .err_nopulse_o(err_nopulse_o),
   .err_bad_o    (err_bad_o)
);

// File: tb/tb_vsm_vsync_meter.sv
module tb_vsm_vsync_meter;
   localparam int CLK_P  = 10;
   localparam int CNT_W  = 12;
   localparam int TO_W   = 12;
   localparam int FRAC_W = 8;
   localparam int NV     = 6;
   // in period, delay to output edge, output period
   localparam int VEC [NV][3] = '{
      '{100, 30, 100},
      '{200, 5, 150},
      '{64, 63, 64},
      '{100, 250, 120},
      '{90, 90, 90},
      '{37, 1, 41}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [TO_W-1:0]   timeout_i = 12'd1000;
   logic              vs_in_i = 1'b0;
   logic              vs_out_i = 1'b0;
   logic [CNT_W-1:0]  in_period_o;
   logic [CNT_W-1:0]  out_period_o;
   logic [CNT_W-1:0]  latency_o;
   logic [FRAC_W-1:0] lat_frac_o;
   logic              valid_o;
   logic              err_nopulse_o;
   logic              err_bad_o;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit finished = 1'b0;
   bit saw_valid;

   vsm_vsync_meter #(.CNT_W(CNT_W), .TO_W(TO_W), .FRAC_W(FRAC_W), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .timeout_i(timeout_i),
      .vs_in_i(vs_in_i), .vs_out_i(vs_out_i),
      .in_period_o(in_period_o), .out_period_o(out_period_o), .latency_o(latency_o),
      .lat_frac_o(lat_frac_o), .valid_o(valid_o), .err_nopulse_o(err_nopulse_o),
      .err_bad_o(err_bad_o)
   );

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      step(1);
      start_i = 1'b0;
   endtask

   // drives two source edges then two output edges at given offsets
   task automatic drive_round(input int per_i, input int dly, input int per_o);
      int t0 = 5;
      int t1 = 5 + per_i;
      int t2 = 5 + per_i + dly;
      int t3 = 5 + per_i + dly + per_o;
      for (int t = 0; t < t3 + 4; t++) begin
         vs_in_i  = ((t >= t0 && t < t0 + 3) || (t >= t1 && t < t1 + 3));
         vs_out_i = ((t >= t2 && t < t2 + 3) || (t >= t3 && t < t3 + 3));
         if (valid_o) saw_valid = 1'b1;
         step(1);
      end
      vs_in_i  = 1'b0;
      vs_out_i = 1'b0;
   endtask

   task automatic wait_end(input int limit);
      for (int i = 0; i < limit; i++) begin
         if (valid_o) saw_valid = 1'b1;
         if (valid_o || err_nopulse_o || err_bad_o) return;
         step(1);
      end
   endtask

   initial begin
      step(3);
      // R1: reset state
      chk("R1 in_period", int'(in_period_o), 0);
      chk("R1 latency", int'(latency_o), 0);
      chk("R1 flags", int'({valid_o, err_nopulse_o, err_bad_o}), 0);
      rst_n = 1'b1;
      step(2);
      chk("R1 flags after release", int'({valid_o, err_nopulse_o, err_bad_o}), 0);

      // R10: edges while idle do nothing
      vs_in_i = 1'b1; step(4); vs_in_i = 1'b0; step(4);
      chk("R10 idle edge", int'(in_period_o), 0);

      // table walk: R2 R3 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         int lm;
         int fr;
         lm = VEC[v][1] % VEC[v][0];
         fr = (lm * (1 << FRAC_W)) / VEC[v][0];
         saw_valid = 1'b0;
         pulse_start();
         drive_round(VEC[v][0], VEC[v][1], VEC[v][2]);
         wait_end(100);
         chk("R6 valid seen", int'(saw_valid), 1);
         step(1);
         chk("R6 valid single cycle", int'(valid_o), 0);
         chk("R2 in period", int'(in_period_o), VEC[v][0]);
         chk("R3 out period", int'(out_period_o), VEC[v][2]);
         chk("R4 latency", int'(latency_o), lm);
         chk("R5 fraction", int'(lat_frac_o), fr);
      end

      // R6 / R10: hold after completion despite sync activity
      vs_in_i = 1'b1; step(3); vs_in_i = 1'b0; step(20);
      vs_out_i = 1'b1; step(3); vs_out_i = 1'b0; step(20);
      chk("R6 hold period", int'(in_period_o), 37);
      chk("R6 hold latency", int'(latency_o), 1);

      // R9: restart mid-round
      pulse_start();
      step(3); vs_in_i = 1'b1; step(3); vs_in_i = 1'b0; step(10);
      saw_valid = 1'b0;
      pulse_start();
      chk("R9 cleared", int'(in_period_o), 0);
      drive_round(80, 20, 80);
      wait_end(100);
      chk("R9 restart period", int'(in_period_o), 80);
      chk("R9 restart latency", int'(latency_o), 20);

      // R7: no edge at all
      timeout_i = 12'd50;
      saw_valid = 1'b0;
      pulse_start();
      step(30);
      chk("R7 not early", int'(err_nopulse_o), 0);
      wait_end(200);
      chk("R7 nopulse flag", int'(err_nopulse_o), 1);
      chk("R7 results zero", int'(in_period_o), 0);
      chk("R7 no valid", int'(saw_valid), 0);

      // R7: second source edge missing
      pulse_start();
      step(3); vs_in_i = 1'b1; step(3); vs_in_i = 1'b0;
      wait_end(200);
      chk("R7 mid-round timeout", int'(err_nopulse_o), 1);
      chk("R7 bad flag low", int'(err_bad_o), 0);

      // R8: counter wrap between the two source stamps
      timeout_i = 12'd1000;
      while ((cyc % 4096) != 3900) step(1);
      saw_valid = 1'b0;
      pulse_start();
      drive_round(300, 10, 60);
      wait_end(200);
      chk("R8 bad flag", int'(err_bad_o), 1);
      chk("R8 results zero", int'(in_period_o), 0);
      chk("R8 no valid", int'(saw_valid), 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule